// File: doc/BRIEF.md
# ADC Sample Format Converter

This block is a single-register streaming stage placed between the raw sample port of an analog-to-digital converter and downstream signed arithmetic. Each raw word is 16 bits wide and carries a sample of `n` valid bits. The sample may sit at the top of the word (left-justified) or at the bottom (right-justified). The stage first brings the sample down to bit 0 and masks it to exactly `n` bits. Only after that does it interpret the code. The code may be straight binary (unipolar), offset-binary or two's-complement. The stage then produces a 32-bit signed sample.

The conversion from offset-binary to signed flips only bit `n-1` and then sign-extends. The bits below that are never inverted. Straight binary is passed on zero-extended and is marked as unipolar. An optional clip stage limits the signed result to a programmable window instead of letting it wrap. The configuration inputs are taken on the same clock edge as the sample they apply to, so they may change between samples without disturbing data that is already in the register.

Top module: `smp_fmt_conv`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. A synchronous reset (`rst` high at an edge) clears `out_valid`, `out_code`, `out_sample` and `out_unipolar` to 0.
- R2: At a clock edge where `in_valid` is low, `out_code`, `out_sample` and `out_unipolar` keep their values.
- R3: With `cfg_left` = 1 the aligned code is `in_raw >> (16 - n)`. With `cfg_left` = 0 it is the low `n` bits of `in_raw`. `out_code` holds this code with every bit at position `n` and above equal to 0.
- R4: The effective resolution `n` is `cfg_res` limited to the range 8 to 16. A value below 8 acts as 8 and a value above 16 acts as 16.
- R5: With `cfg_fmt` = 0 (straight binary), `out_sample` equals the code zero-extended and `out_unipolar` is 1.
- R6: With `cfg_fmt` = 1 (offset-binary), `out_sample` equals code − 2^(n−1) and `out_unipolar` is 0. For n=12: 0x800 gives 0, 0x000 gives −2048 and 0xFFF gives +2047.
- R7: With `cfg_fmt` = 2 or 3 (two's-complement), `out_sample` is the code sign-extended from bit `n-1`, and `out_unipolar` is 0. For n=8, 0x80 gives −128. For n=16, 0x8000 gives −32768.
- R8: With `cfg_sat_en` = 1, a result above `cfg_sat_hi` becomes `cfg_sat_hi`. Otherwise a result below `cfg_sat_lo` becomes `cfg_sat_lo`. Both limits are compared as signed values, and the upper limit is tested first. With `cfg_sat_en` = 0 no clipping takes place.
- R9: All configuration inputs are used as they stand at the edge where the sample is captured. Configuration changes at any other edge have no effect on the held output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw sample strobe |
| in_raw | input | 16 | Raw converter word |
| cfg_res | input | 5 | Requested resolution n |
| cfg_left | input | 1 | 1: sample is left-justified, 0: right-justified |
| cfg_fmt | input | 2 | Source code: 0 straight, 1 offset, 2/3 two's-complement |
| cfg_sat_en | input | 1 | Enable clipping to the signed window |
| cfg_sat_lo | input | 32 | Lower clip limit (signed) |
| cfg_sat_hi | input | 32 | Upper clip limit (signed) |
| out_valid | output | 1 | Registered sample strobe |
| out_code | output | 16 | Aligned, masked n-bit code |
| out_sample | output | 32 | Signed sample after interpretation and clipping |
| out_unipolar | output | 1 | Set when the source was straight binary |

## Verification
The assertions check the following properties on every cycle:
- The one-cycle valid latency and the reset clearing.
- That held outputs stay still while no sample arrives.
- That the aligned code never carries bits at position `n` or above.
- That signed results stay inside the n-bit signed range, or inside the clip window when clipping is enabled.
- That straight-binary results equal the zero-extended code with the unipolar flag set.

The exact mapping of each format cannot be shown by a cycle property and needs the bench's scenarios. These cover the MSB-only flip, the boundary codes at mid-scale and both ends, left versus right shift amounts, the resolution clamp, and the priority of the upper clip limit.

// File: rtl/smpfmt_pkg.sv
package smpfmt_pkg;

   // Source code formats; the encoding is fixed by the cfg_fmt port.
   typedef enum logic [1:0] {
      FMT_STRAIGHT = 2'd0,
      FMT_OFFSET   = 2'd1,
      FMT_TWOS     = 2'd2,
      FMT_TWOS_ALT = 2'd3
   } src_fmt_e;

   localparam int unsigned RAW_W_DEF  = 16;
   localparam int unsigned SMP_W_DEF  = 32;
   localparam int unsigned MIN_RES_DEF = 8;

   function automatic int unsigned res_bits(input int unsigned cont_w);
      return $clog2(cont_w + 1);
   endfunction

endpackage

// File: rtl/smpfmt_align.sv
// Brings an n-bit sample to bit 0 and masks it to n bits.
module smpfmt_align #(
   parameter int unsigned RAW_W   = 16,
   parameter int unsigned MIN_RES = 8,
   localparam int unsigned RES_W  = $clog2(RAW_W + 1)
) (
   input  logic [RAW_W-1:0] raw,
   input  logic [RES_W-1:0] res_req,
   input  logic             left_just,
   output logic [RAW_W-1:0] code,
   output logic [RAW_W-1:0] msb_sel,
   output logic [RES_W-1:0] res_eff
);

   logic [RES_W-1:0] shamt;
   logic [RAW_W:0]   pow_n;
   logic [RAW_W-1:0] keep_mask;
   logic [RAW_W-1:0] shifted;

   // Resolution clamp into the legal window.
   always_comb begin
      if (res_req < RES_W'(MIN_RES))
         res_eff = RES_W'(MIN_RES);
      else if (res_req > RES_W'(RAW_W))
         res_eff = RES_W'(RAW_W);
      else
         res_eff = res_req;
   end

   // 2^n as a one-hot vector one bit wider than the container.
   assign pow_n     = {{RAW_W{1'b0}}, 1'b1} << res_eff;
   assign keep_mask = pow_n[RAW_W-1:0] - {{(RAW_W-1){1'b0}}, 1'b1};
   assign msb_sel   = pow_n[RAW_W:1];

   assign shamt   = left_just ? (RES_W'(RAW_W) - res_eff) : '0;
   assign shifted = raw >> shamt;
   assign code    = shifted & keep_mask;

endmodule

// File: rtl/smpfmt_interp.sv
// Interprets an aligned code according to its source format.
module smpfmt_interp
   import smpfmt_pkg::*;
#(
   parameter int unsigned RAW_W = 16,
   parameter int unsigned SMP_W = 32
) (
   input  logic [RAW_W-1:0] code,
   input  logic [RAW_W-1:0] msb_sel,
   input  src_fmt_e         fmt,
   output logic [SMP_W-1:0] sample,
   output logic             unipolar
);

   logic [RAW_W-1:0] conv;
   logic [RAW_W-1:0] upper_sel;
   logic             neg;
   logic             is_straight;

   assign is_straight = (fmt == FMT_STRAIGHT);

   // Offset-binary: flip only the sign position, never the rest.
   always_comb begin
      unique case (fmt)
         FMT_OFFSET: conv = code ^ msb_sel;
         default:    conv = code;
      endcase
   end

   // Positions strictly above bit n-1 inside the container.
   assign upper_sel = ~((msb_sel << 1) - {{(RAW_W-1){1'b0}}, 1'b1}) & ~msb_sel;
   assign neg       = !is_straight && ((conv & msb_sel) != '0);
   assign unipolar  = is_straight;

   for (genvar i = 0; i < SMP_W; i++) begin : g_ext
      if (i < RAW_W) begin : g_in
         assign sample[i] = conv[i] | (neg & upper_sel[i]);
      end else begin : g_out
         assign sample[i] = neg;
      end
   end

endmodule

// File: rtl/smpfmt_clip.sv
// Optional signed window limiter; ENABLE=0 builds a wire.
module smpfmt_clip #(
   parameter int unsigned SMP_W  = 32,
   parameter bit          ENABLE = 1'b1
) (
   input  logic [SMP_W-1:0] din,
   input  logic             sat_en,
   input  logic [SMP_W-1:0] lim_lo,
   input  logic [SMP_W-1:0] lim_hi,
   output logic [SMP_W-1:0] dout
);

   if (ENABLE) begin : g_clip
      logic above;
      logic below;
      assign above = $signed(din) > $signed(lim_hi);
      assign below = $signed(din) < $signed(lim_lo);
      always_comb begin
         if (sat_en && above)
            dout = lim_hi;
         else if (sat_en && below)
            dout = lim_lo;
         else
            dout = din;
      end
   end else begin : g_pass
      logic unused_ok;
      assign unused_ok = sat_en ^ (^lim_lo) ^ (^lim_hi);
      assign dout = din;
   end

endmodule

// File: rtl/smp_fmt_conv.sv
module smp_fmt_conv
   import smpfmt_pkg::*;
#(
   parameter int unsigned RAW_W   = RAW_W_DEF,
   parameter int unsigned SMP_W   = SMP_W_DEF,
   parameter int unsigned MIN_RES = MIN_RES_DEF,
   parameter bit          HAS_CLIP = 1'b1,
   localparam int unsigned RES_W  = $clog2(RAW_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [RAW_W-1:0] in_raw,
   input  logic [RES_W-1:0] cfg_res,
   input  logic             cfg_left,
   input  logic [1:0]       cfg_fmt,
   input  logic             cfg_sat_en,
   input  logic [SMP_W-1:0] cfg_sat_lo,
   input  logic [SMP_W-1:0] cfg_sat_hi,
   output logic             out_valid,
   output logic [RAW_W-1:0] out_code,
   output logic [SMP_W-1:0] out_sample,
   output logic             out_unipolar
);

   // Elaboration-time parameter checks.
   if (RAW_W < 2) begin : g_bad_raw
      $error("smp_fmt_conv: RAW_W must be at least 2");
   end
   if (MIN_RES < 2 || MIN_RES > RAW_W) begin : g_bad_min
      $error("smp_fmt_conv: MIN_RES must lie in 2..RAW_W");
   end
   if (SMP_W <= RAW_W) begin : g_bad_smp
      $error("smp_fmt_conv: SMP_W must exceed RAW_W");
   end

   logic [RAW_W-1:0] al_code;
   logic [RAW_W-1:0] al_msb;
   logic [RES_W-1:0] al_res;
   logic [SMP_W-1:0] ip_sample;
   logic             ip_unipolar;
   logic [SMP_W-1:0] cl_sample;
   src_fmt_e         fmt_in;

   assign fmt_in = src_fmt_e'(cfg_fmt);

   smpfmt_align #(
      .RAW_W   (RAW_W),
      .MIN_RES (MIN_RES)
   ) u_align (
      .raw       (in_raw),
      .res_req   (cfg_res),
      .left_just (cfg_left),
      .code      (al_code),
      .msb_sel   (al_msb),
      .res_eff   (al_res)
   );

   smpfmt_interp #(
      .RAW_W (RAW_W),
      .SMP_W (SMP_W)
   ) u_interp (
      .code     (al_code),
      .msb_sel  (al_msb),
      .fmt      (fmt_in),
      .sample   (ip_sample),
      .unipolar (ip_unipolar)
   );

   smpfmt_clip #(
      .SMP_W  (SMP_W),
      .ENABLE (HAS_CLIP)
   ) u_clip (
      .din    (ip_sample),
      .sat_en (cfg_sat_en),
      .lim_lo (cfg_sat_lo),
      .lim_hi (cfg_sat_hi),
      .dout   (cl_sample)
   );

   logic unused_res;
   assign unused_res = ^al_res;

   // Single pipeline register; data loads only with a valid sample.
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_code     <= '0;
         out_sample   <= '0;
         out_unipolar <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_code     <= al_code;
            out_sample   <= cl_sample;
            out_unipolar <= ip_unipolar;
         end
      end
   end

endmodule

// File: rtl/smpfmt_chk.sv
module smpfmt_chk #(
   parameter int unsigned RAW_W   = 16,
   parameter int unsigned SMP_W   = 32,
   parameter int unsigned MIN_RES = 8,
   localparam int unsigned RES_W  = $clog2(RAW_W + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [RAW_W-1:0] in_raw,
   input logic [RES_W-1:0] cfg_res,
   input logic             cfg_left,
   input logic [1:0]       cfg_fmt,
   input logic             cfg_sat_en,
   input logic [SMP_W-1:0] cfg_sat_lo,
   input logic [SMP_W-1:0] cfg_sat_hi,
   input logic             out_valid,
   input logic [RAW_W-1:0] out_code,
   input logic [SMP_W-1:0] out_sample,
   input logic             out_unipolar
);

   logic        live = 1'b0;
   int unsigned n_q;
   logic [1:0]  fmt_q;
   logic        sat_q;
   logic signed [SMP_W-1:0] lo_q, hi_q;
   longint      s_val, half;

   always_ff @(posedge clk) begin
      live <= !rst;
      if (in_valid) begin
         n_q   <= (int'(cfg_res) < int'(MIN_RES)) ? MIN_RES :
                  (int'(cfg_res) > int'(RAW_W)) ? RAW_W : int'(cfg_res);
         fmt_q <= cfg_fmt;
         sat_q <= cfg_sat_en;
         lo_q  <= cfg_sat_lo;
         hi_q  <= cfg_sat_hi;
      end
   end

   always_comb begin
      s_val = longint'($signed(out_sample));
      half  = longint'(1) << (n_q - 1);
   end

   logic unused_in;
   assign unused_in = ^in_raw ^ cfg_left;

   // R1
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
      live |-> out_valid == $past(in_valid));
   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && out_code == '0 && out_sample == '0 && !out_unipolar));
   // R2
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (live && !$past(in_valid)) |->
         ($stable(out_code) && $stable(out_sample) && $stable(out_unipolar)));
   // R3
   a_r3_code_width: assert property (@(posedge clk) disable iff (rst)
      (live && out_valid) |-> ((out_code >> n_q) == '0));
   // R5
   a_r5_straight_zext: assert property (@(posedge clk) disable iff (rst)
      (live && out_valid && fmt_q == 2'd0 && !sat_q) |->
         (out_unipolar && out_sample == SMP_W'(out_code)));
   // R6 R7
   a_r7_signed_range: assert property (@(posedge clk) disable iff (rst)
      (live && out_valid && fmt_q != 2'd0 && !sat_q) |->
         (!out_unipolar && s_val >= -half && s_val <= half - 1));
   // R8
   a_r8_within_window: assert property (@(posedge clk) disable iff (rst)
      (live && out_valid && sat_q && lo_q <= hi_q) |->
         (s_val >= longint'(lo_q) && s_val <= longint'(hi_q)));

endmodule

bind smp_fmt_conv smpfmt_chk #(
   .RAW_W   (RAW_W),
   .SMP_W   (SMP_W),
   .MIN_RES (MIN_RES)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .in_raw       (in_raw),
   .cfg_res      (cfg_res),
   .cfg_left     (cfg_left),
   .cfg_fmt      (cfg_fmt),
   .cfg_sat_en   (cfg_sat_en),
   .cfg_sat_lo   (cfg_sat_lo),
   .cfg_sat_hi   (cfg_sat_hi),
   .out_valid    (out_valid),
   .out_code     (out_code),
   .out_sample   (out_sample),
   .out_unipolar (out_unipolar)
);

// File: tb/tb_smp_fmt_conv.sv
module tb_smp_fmt_conv;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_raw = '0;
   logic [4:0]  cfg_res = 5'd12;
   logic        cfg_left = 1'b0;
   logic [1:0]  cfg_fmt = 2'd0;
   logic        cfg_sat_en = 1'b0;
   logic [31:0] cfg_sat_lo = '0;
   logic [31:0] cfg_sat_hi = '0;
   logic        out_valid;
   logic [15:0] out_code;
   logic [31:0] out_sample;
   logic        out_unipolar;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   smp_fmt_conv dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_raw(in_raw),
      .cfg_res(cfg_res), .cfg_left(cfg_left), .cfg_fmt(cfg_fmt),
      .cfg_sat_en(cfg_sat_en), .cfg_sat_lo(cfg_sat_lo), .cfg_sat_hi(cfg_sat_hi),
      .out_valid(out_valid), .out_code(out_code), .out_sample(out_sample),
      .out_unipolar(out_unipolar)
   );

   // Behavioural reference, arithmetic form of the requirements.
   int exp_valid = 0, exp_code = 0, exp_sample = 0, exp_uni = 0;

   task automatic model(input int raw, input int res, input bit left, input int fmt,
                        input bit sen, input int lo, input int hi,
                        output int code, output int s, output int uni);
      int n;
      n = (res < 8) ? 8 : (res > 16) ? 16 : res;          // R4
      code = left ? (raw >> (16 - n)) : (raw % (1 << n)); // R3
      if (fmt == 0) begin s = code; uni = 1; end           // R5
      else if (fmt == 1) begin s = code - (1 << (n - 1)); uni = 0; end // R6
      else begin s = (code >= (1 << (n - 1))) ? code - (1 << n) : code; uni = 0; end // R7
      if (sen) begin                                       // R8
         if (s > hi) s = hi;
         else if (s < lo) s = lo;
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         exp_valid = 0; exp_code = 0; exp_sample = 0; exp_uni = 0;
      end else begin
         exp_valid = int'(in_valid);
         if (in_valid)
            model(int'(in_raw), int'(cfg_res), cfg_left, int'(cfg_fmt), cfg_sat_en,
                  $signed(cfg_sat_lo), $signed(cfg_sat_hi), exp_code, exp_sample, exp_uni);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R1 valid", int'(out_valid), exp_valid);
         check("R3 code", int'(out_code), exp_code);
         check("R2/R6/R7 sample", $signed(out_sample), exp_sample);
         check("R5 unipolar", int'(out_unipolar), exp_uni);
      end
   end

   task automatic send(input int raw, input int res, input bit left, input int fmt,
                       input bit sen, input int lo, input int hi);
      @(negedge clk);
      in_raw = raw[15:0]; cfg_res = res[4:0]; cfg_left = left; cfg_fmt = fmt[1:0];
      cfg_sat_en = sen; cfg_sat_lo = lo; cfg_sat_hi = hi; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      #1;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", int'(out_valid), 0);
      check("R1 reset sample", int'(out_sample), 0);
      check("R1 reset code", int'(out_code), 0);
      rst = 1'b0;

      send('hABC0, 12, 1, 0, 0, 0, 0);
      check("R3 left code", int'(out_code), 'hABC);
      check("R5 straight sample", $signed(out_sample), 2748);
      check("R5 unipolar flag", int'(out_unipolar), 1);
      send('hFABC, 12, 0, 0, 0, 0, 0);
      check("R3 right mask", int'(out_code), 'hABC);

      send('h800, 12, 0, 1, 0, 0, 0);
      check("R6 mid is zero", $signed(out_sample), 0);
      send('h000, 12, 0, 1, 0, 0, 0);
      check("R6 bottom", $signed(out_sample), -2048);
      send('hFFF, 12, 0, 1, 0, 0, 0);
      check("R6 top", $signed(out_sample), 2047);
      check("R6 unipolar low", int'(out_unipolar), 0);

      send('h0080, 8, 0, 2, 0, 0, 0);
      check("R7 n8 min", $signed(out_sample), -128);
      send('h8000, 16, 1, 3, 0, 0, 0);
      check("R7 n16 min", $signed(out_sample), -32768);
      send('h7FFF, 16, 0, 2, 0, 0, 0);
      check("R7 n16 max", $signed(out_sample), 32767);

      send('h01FF, 4, 0, 2, 0, 0, 0);
      check("R4 low clamp", $signed(out_sample), -1);
      send('h8001, 20, 1, 0, 0, 0, 0);
      check("R4 high clamp", $signed(out_sample), 32769);

      send('h7FF, 12, 0, 2, 1, -100, 100);
      check("R8 clip high", $signed(out_sample), 100);
      send('h800, 12, 0, 2, 1, -100, 100);
      check("R8 clip low", $signed(out_sample), -100);
      send('h005, 12, 0, 2, 1, -100, 100);
      check("R8 inside", $signed(out_sample), 5);
      send('h7FF, 12, 0, 2, 0, -100, 100);
      check("R8 disabled", $signed(out_sample), 2047);
      send('h7FF, 12, 0, 2, 1, 50, 10);
      check("R8 upper first", $signed(out_sample), 10);

      // R2 and R9: idle cycles with moving data and configuration
      send('h123, 12, 0, 0, 0, 0, 0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_raw = 16'hFFFF; cfg_fmt = 2'd2; cfg_res = 5'd8; cfg_sat_en = 1'b1;
      end
      #1;
      check("R2 held sample", $signed(out_sample), 'h123);
      check("R9 config ignored", int'(out_code), 'h123);
      check("R1 valid dropped", int'(out_valid), 0);

      // Random stream, configuration changing every cycle (R9)
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         in_valid   = ($urandom % 4) != 0;
         in_raw     = 16'($urandom);
         cfg_res    = 5'(6 + ($urandom % 12));
         cfg_left   = 1'($urandom);
         cfg_fmt    = 2'($urandom);
         cfg_sat_en = ($urandom % 3) == 0;
         cfg_sat_lo = 32'(-int'($urandom % 40000));
         cfg_sat_hi = 32'($urandom % 40000);
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule